// File: doc/BRIEF.md
# Serial Register Port for a Data Converter

This block is the serial slave front end of a data converter's register bank. A host lowers the active-low frame select and clocks 16 bits in on the serial data input. The top two bits of each frame name the target register and the low 14 bits are its payload. Nothing is written until the sixteenth bit has arrived. A frame cut short leaves the bank as it was.

Reads are addressed indirectly. A two-bit read-select field in the control register chooses what every later frame shifts out. The choices are the conversion result, the test register, the calibration bank and the status word. The field keeps its value until the control register is written again. The serial output shifts at the same time as the input, so each frame returns a read.

The calibration bank has ten registers. A two-bit group field in the control register picks a group. A step pointer moves through that group, one register per frame that touches it. The conversion result and the status word come in on input ports. The serial pins are oversampled in the system clock domain.

Top module: `conv_reg_port`

## Requirements
- R1: A frame has 16 bits, MSB first, sampled on rising serial clock edges while frame select is low. Bits 15:14 are the write address and bits 13:0 the payload. The target register changes only after the sixteenth bit. Further bits in the same frame are ignored.
- R2: If frame select rises before the sixteenth bit, no register changes and the calibration step pointer keeps its value.
- R3: Write address 00 discards its payload. With the data input held low, every frame decodes to 00, and the block behaves as a read-only device that keeps returning its current read source.
- R4: Write address 01 loads the payload into the test register. With read-select 01, a frame returns {2'b00, test}.
- R5: Write address 11 loads the control register. Control bits 7:6 are the read-select field: 00 conversion result, 01 test, 10 calibration, 11 status. The field is sampled when a frame starts and governs every later frame until the control register is rewritten.
- R6: With read-select 00, a frame returns four zero bits followed by the 12-bit conversion result.
- R7: With read-select 11, a frame returns the 16-bit status input unchanged.
- R8: Control bits 9:8 pick a calibration group. 00 is the eight trim registers (indices 0 to 7). 01 is offset then gain (indices 8, 9). 10 is offset only. 11 is gain only. Write address 10 writes the register under the step pointer. A read with read-select 10 returns {2'b00, that register}. The pointer advances by one, wrapping within the group, after each complete frame that writes address 10 or was read with read-select 10. A control write resets the pointer to the start of its group.
- R9: The output bit is driven MSB first. The first bit is valid before the first rising serial clock edge, and the output shifts on each falling edge. After 16 bits it outputs zeros.
- R10: Reset clears the control, test and calibration registers and the step pointer. The output is low whenever no frame is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial data into the block |
| conv_result | input | 12 | Latest conversion result |
| status_word | input | 16 | Status word returned for read-select 11 |
| sdo | output | 1 | Serial data out of the block |

## Verification
The assertions check the following on every cycle:
- The frame receiver never counts past sixteen bits, commits at most once per frame, and commits only while a frame is active.
- A null-address commit leaves the bank untouched, a test-address commit lands its payload, and the control register changes only on its own commit.
- The step pointer stays inside its group and returns to zero after a control write.
- The output holds between falling edges and is low when idle.

Only the bench's frame sequences can show that the read-select field persists across frames, that the pointer wraps within each group size, that a short frame is lost and an overlong frame is still accepted, and that the returned bit streams carry the right padding.

// File: rtl/conv_reg_pkg.sv
`timescale 1ns/1ps
package conv_reg_pkg;

  localparam int FRAME_W    = 16;
  localparam int ADDR_W     = 2;
  localparam int PAY_W      = FRAME_W - ADDR_W;
  localparam int CNT_W      = $clog2(FRAME_W + 1);
  localparam int RES_W      = 12;
  localparam int N_TRIM     = 8;
  localparam int N_CAL      = N_TRIM + 2;
  localparam int CAL_IDX_W  = $clog2(N_CAL);
  localparam int STEP_W     = $clog2(N_TRIM);
  localparam int RDSEL_LSB  = 6;
  localparam int CALSEL_LSB = 8;
  localparam int OFFSET_IDX = N_TRIM;
  localparam int GAIN_IDX   = N_TRIM + 1;

  typedef logic [FRAME_W-1:0] frame_t;
  typedef logic [PAY_W-1:0]   payload_t;

  typedef enum logic [ADDR_W-1:0] {
    WA_NONE = 2'b00,
    WA_TEST = 2'b01,
    WA_CAL  = 2'b10,
    WA_CTRL = 2'b11
  } wr_addr_e;

  typedef enum logic [1:0] {
    RS_RESULT = 2'b00,
    RS_TEST   = 2'b01,
    RS_CAL    = 2'b10,
    RS_STATUS = 2'b11
  } rd_sel_e;

  // first bank index of a calibration group
  function automatic logic [CAL_IDX_W-1:0] cal_base(input logic [1:0] grp);
    case (grp)
      2'b00:   return '0;
      2'b01:   return CAL_IDX_W'(OFFSET_IDX);
      2'b10:   return CAL_IDX_W'(OFFSET_IDX);
      default: return CAL_IDX_W'(GAIN_IDX);
    endcase
  endfunction

  // number of registers in a calibration group
  function automatic logic [STEP_W:0] cal_len(input logic [1:0] grp);
    case (grp)
      2'b00:   return (STEP_W+1)'(N_TRIM);
      2'b01:   return (STEP_W+1)'(2);
      default: return (STEP_W+1)'(1);
    endcase
  endfunction

  function automatic logic [STEP_W-1:0] next_step(input logic [STEP_W-1:0] s,
                                                  input logic [1:0] grp);
    logic [STEP_W:0] nxt;
    nxt = {1'b0, s} + 1'b1;
    if (nxt >= cal_len(grp)) return '0;
    return nxt[STEP_W-1:0];
  endfunction

endpackage

// File: rtl/ser_edge_sync.sv
`timescale 1ns/1ps
module ser_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic sdi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_act,
  output logic cs_start,
  output logic sdi_s
);

  logic [STAGES-1:0] sclk_q, sclk_d;
  logic [STAGES-1:0] csn_q,  csn_d;
  logic [STAGES-1:0] sdi_q,  sdi_d;
  logic              sclk_prev_q, act_prev_q;

  // equal-depth pipes keep data aligned with the clock it rides on
  always_comb begin
    sclk_d = {sclk_q[STAGES-2:0], sclk};
    csn_d  = {csn_q[STAGES-2:0],  cs_n};
    sdi_d  = {sdi_q[STAGES-2:0],  sdi};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q      <= '0;
      csn_q       <= '1;
      sdi_q       <= '0;
      sclk_prev_q <= 1'b0;
      act_prev_q  <= 1'b0;
    end else begin
      sclk_q      <= sclk_d;
      csn_q       <= csn_d;
      sdi_q       <= sdi_d;
      sclk_prev_q <= sclk_q[STAGES-1];
      act_prev_q  <= cs_act;
    end
  end

  assign sclk_rise = sclk_q[STAGES-1] & ~sclk_prev_q;
  assign sclk_fall = ~sclk_q[STAGES-1] & sclk_prev_q;
  assign cs_act    = ~csn_q[STAGES-1];
  assign cs_start  = cs_act & ~act_prev_q;
  assign sdi_s     = sdi_q[STAGES-1];

endmodule

// File: rtl/frame_rx.sv
`timescale 1ns/1ps
module frame_rx
  import conv_reg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   sclk_rise,
  input  logic   cs_act,
  input  logic   sdi_s,
  output logic   commit,
  output frame_t frame_word
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  frame_t           sh_q, sh_d;
  logic             commit_q, commit_d;

  always_comb begin
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    commit_d = 1'b0;
    if (!cs_act) begin
      cnt_d = '0;
    end else if (sclk_rise && (cnt_q < CNT_W'(FRAME_W))) begin
      sh_d     = {sh_q[FRAME_W-2:0], sdi_s};
      cnt_d    = cnt_q + 1'b1;
      commit_d = (cnt_q == CNT_W'(FRAME_W - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      sh_q     <= '0;
      commit_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      sh_q     <= sh_d;
      commit_q <= commit_d;
    end
  end

  assign commit     = commit_q;
  assign frame_word = sh_q;

  // R1: bit counter saturates at one frame
  a_r1_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(FRAME_W));

  // R1: one commit pulse per frame
  a_r1_commit_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |=> !commit_q);

  // R2: a commit needs an active frame
  a_r2_commit_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    commit_q |-> $past(cs_act));

endmodule

// File: rtl/reg_bank.sv
`timescale 1ns/1ps
module reg_bank
  import conv_reg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             commit,
  input  frame_t           frame_word,
  input  logic             cs_start,
  input  logic [RES_W-1:0] conv_result,
  input  frame_t           status_word,
  output frame_t           rd_word
);

  payload_t                        ctrl_q, ctrl_d;
  payload_t                        test_q, test_d;
  logic [N_CAL-1:0][PAY_W-1:0]     cal_q,  cal_d;
  logic [STEP_W-1:0]               step_q, step_d;
  rd_sel_e                         frame_rd_q, frame_rd_d;

  wr_addr_e             addr;
  payload_t             pay;
  logic [1:0]           cal_grp;
  rd_sel_e              rd_sel;
  logic [CAL_IDX_W-1:0] cal_idx;

  assign addr    = wr_addr_e'(frame_word[FRAME_W-1 -: ADDR_W]);
  assign pay     = frame_word[PAY_W-1:0];
  assign cal_grp = ctrl_q[CALSEL_LSB +: 2];
  assign rd_sel  = rd_sel_e'(ctrl_q[RDSEL_LSB +: 2]);
  assign cal_idx = cal_base(cal_grp) + CAL_IDX_W'(step_q);

  always_comb begin
    ctrl_d     = ctrl_q;
    test_d     = test_q;
    cal_d      = cal_q;
    step_d     = step_q;
    frame_rd_d = cs_start ? rd_sel : frame_rd_q;
    if (commit) begin
      case (addr)
        WA_TEST: test_d         = pay;
        WA_CAL:  cal_d[cal_idx] = pay;
        WA_CTRL: ctrl_d         = pay;
        default: ;
      endcase
      if (addr == WA_CTRL)
        step_d = '0;
      else if ((addr == WA_CAL) || (frame_rd_q == RS_CAL))
        step_d = next_step(step_q, cal_grp);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      test_q     <= '0;
      cal_q      <= '0;
      step_q     <= '0;
      frame_rd_q <= RS_RESULT;
    end else begin
      ctrl_q     <= ctrl_d;
      test_q     <= test_d;
      cal_q      <= cal_d;
      step_q     <= step_d;
      frame_rd_q <= frame_rd_d;
    end
  end

  always_comb begin
    case (rd_sel)
      RS_RESULT: rd_word = {{(FRAME_W-RES_W){1'b0}}, conv_result};
      RS_TEST:   rd_word = {{ADDR_W{1'b0}}, test_q};
      RS_CAL:    rd_word = {{ADDR_W{1'b0}}, cal_q[cal_idx]};
      default:   rd_word = status_word;
    endcase
  end

  // R3: null address leaves the whole bank untouched
  a_r3_null_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == WA_NONE) |=> ($stable(ctrl_q) && $stable(test_q) && $stable(cal_q)));

  // R4: test write lands its payload
  a_r4_test_takes_payload: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == WA_TEST) |=> (test_q == $past(frame_word[PAY_W-1:0])));

  // R5: control changes only on its own commit
  a_r5_ctrl_only_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && addr == WA_CTRL) |=> $stable(ctrl_q));

  // R8: pointer stays inside the selected group
  a_r8_step_in_group: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, step_q} < cal_len(ctrl_q[CALSEL_LSB +: 2])));

  // R8: control write restarts the pointer
  a_r8_ctrl_resets_step: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && addr == WA_CTRL) |=> (step_q == '0));

endmodule

// File: rtl/tx_shift.sv
`timescale 1ns/1ps
module tx_shift
  import conv_reg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cs_start,
  input  logic   cs_act,
  input  logic   sclk_fall,
  input  frame_t load_word,
  output logic   sdo
);

  frame_t q, d;

  always_comb begin
    d = q;
    if (cs_start)
      d = load_word;
    else if (!cs_act)
      d = '0;
    else if (sclk_fall)
      d = {q[FRAME_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end

  assign sdo = q[FRAME_W-1];

  // R9: output holds between falling edges inside a frame
  a_r9_hold_between_falls: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !cs_start && !sclk_fall) |=> $stable(sdo));

  // R10: output low while no frame is active
  a_r10_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !sdo);

endmodule

// File: rtl/conv_reg_port.sv
`timescale 1ns/1ps
module conv_reg_port
  import conv_reg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             sdi,
  input  logic [RES_W-1:0] conv_result,
  input  logic [FRAME_W-1:0] status_word,
  output logic             sdo
);

  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic   sclk_rise, sclk_fall, cs_act, cs_start, sdi_s;
  logic   commit;
  frame_t frame_word, rd_word;

  ser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .sclk      (sclk),
    .cs_n      (cs_n),
    .sdi       (sdi),
    .sclk_rise (sclk_rise),
    .sclk_fall (sclk_fall),
    .cs_act    (cs_act),
    .cs_start  (cs_start),
    .sdi_s     (sdi_s)
  );

  frame_rx u_rx (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .sclk_rise  (sclk_rise),
    .cs_act     (cs_act),
    .sdi_s      (sdi_s),
    .commit     (commit),
    .frame_word (frame_word)
  );

  reg_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .commit      (commit),
    .frame_word  (frame_word),
    .cs_start    (cs_start),
    .conv_result (conv_result),
    .status_word (status_word),
    .rd_word     (rd_word)
  );

  tx_shift u_tx (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .cs_start  (cs_start),
    .cs_act    (cs_act),
    .sclk_fall (sclk_fall),
    .load_word (rd_word),
    .sdo       (sdo)
  );

endmodule

// File: tb/conv_reg_port_tb.sv
`timescale 1ns/1ps
module conv_reg_port_tb;

  localparam int HALF = 8;
  localparam int NVEC = 26;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclk = 1'b0;
  logic        cs_n = 1'b1;
  logic        sdi = 1'b0;
  logic [11:0] conv_result = 12'hA5C;
  logic [15:0] status_word = 16'h3C91;
  logic        sdo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  conv_reg_port u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .sdi(sdi),
    .conv_result(conv_result), .status_word(status_word), .sdo(sdo)
  );

  // {requirement, write frame, expected read during that frame}
  localparam logic [39:0] VEC [NVEC] = '{
    {8'd6, 16'h0000, 16'h0A5C},  // R6 default read source
    {8'd3, 16'h0000, 16'h0A5C},  // R3 all-zero input stays read-only
    {8'd4, 16'h5234, 16'h0A5C},  // R4 test <= 0x1234
    {8'd5, 16'hC040, 16'h0A5C},  // R5 read-select 01
    {8'd4, 16'h0000, 16'h1234},  // R4 test readback
    {8'd3, 16'h3FFF, 16'h1234},  // R3 null address, payload dropped
    {8'd3, 16'h0000, 16'h1234},  // R3 test unchanged
    {8'd5, 16'hC0C0, 16'h1234},  // R5 read-select 11
    {8'd7, 16'h0000, 16'h3C91},  // R7 status
    {8'd5, 16'h0000, 16'h3C91},  // R5 selection persists
    {8'd8, 16'hC180, 16'h3C91},  // R8 group 01, read cal
    {8'd8, 16'h8111, 16'h0000},  // R8 offset <= 0x111
    {8'd8, 16'h8222, 16'h0000},  // R8 gain <= 0x222, wrap
    {8'd8, 16'h0000, 16'h0111},
    {8'd8, 16'h0000, 16'h0222},
    {8'd8, 16'h0000, 16'h0111},
    {8'd8, 16'hC180, 16'h0222},  // R8 rewrite restarts pointer
    {8'd8, 16'h0000, 16'h0111},
    {8'd8, 16'hC380, 16'h0222},  // R8 group 11 gain only
    {8'd8, 16'h0000, 16'h0222},
    {8'd8, 16'h0000, 16'h0222},
    {8'd8, 16'hC280, 16'h0222},  // R8 group 10 offset only
    {8'd8, 16'h0000, 16'h0111},
    {8'd8, 16'hC080, 16'h0111},  // R8 group 00 trim bank
    {8'd8, 16'h8AAA, 16'h0000},  // trim0 <= 0x0AAA
    {8'd8, 16'hBFFF, 16'h0000}   // trim1 <= 0x3FFF
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input int req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input logic [15:0] w, input int nb, output logic [16:0] r);
    r = '0;
    @(posedge clk); #1 cs_n = 1'b0;
    repeat (HALF) @(posedge clk);
    for (int i = 0; i < nb; i++) begin
      #1 sdi = (i < 16) ? w[15-i] : 1'b1;
      repeat (HALF-1) @(posedge clk);
      #1 r = {r[15:0], sdo};
      @(posedge clk); #1 sclk = 1'b1;
      repeat (HALF) @(posedge clk); #1 sclk = 1'b0;
    end
    repeat (HALF) @(posedge clk);
    #1 cs_n = 1'b1; sdi = 1'b0;
    repeat (2*HALF) @(posedge clk);
  endtask

  initial begin
    logic [16:0] rd;
    repeat (10) @(posedge clk);
    #1 check({31'd0, sdo}, 32'd0, 10);  // R10 output low in reset
    rst_n = 1'b1;
    repeat (10) @(posedge clk);
    #1 check({31'd0, sdo}, 32'd0, 10);  // R10 idle after reset

    for (int v = 0; v < NVEC; v++) begin
      xfer(VEC[v][31:16], 16, rd);
      check({16'd0, rd[15:0]}, {16'd0, VEC[v][15:0]}, int'(VEC[v][39:32]));
    end

    // R2: short control frame is dropped; pointer at trim2
    xfer(16'hC000, 10, rd);
    for (int k = 2; k < 8; k++) begin
      xfer(16'h0000, 16, rd);
      check({16'd0, rd[15:0]}, 32'd0, 2);
    end
    xfer(16'h0000, 16, rd);
    check({16'd0, rd[15:0]}, 32'h0AAA, 8);  // R8 wrap to trim0
    xfer(16'h0000, 16, rd);
    check({16'd0, rd[15:0]}, 32'h3FFF, 8);

    // R1/R9: 17-bit frame, extra bit ignored, trailing output zero
    xfer(16'h4555, 17, rd);
    check({15'd0, rd}, 32'd0, 9);
    xfer(16'hC040, 16, rd);
    check({16'd0, rd[15:0]}, 32'd0, 8);     // trim3
    xfer(16'h0000, 16, rd);
    check({16'd0, rd[15:0]}, 32'h0555, 1);  // R1 test committed
    #1 check({31'd0, sdo}, 32'd0, 10);      // R10 idle low

    // R10: reset clears control and test
    #1 rst_n = 1'b0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (10) @(posedge clk);
    xfer(16'h0000, 16, rd);
    check({16'd0, rd[15:0]}, 32'h0A5C, 10);
    xfer(16'hC040, 16, rd);
    xfer(16'h0000, 16, rd);
    check({16'd0, rd[15:0]}, 32'h0000, 10);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule